// File: doc/BRIEF.md
# Single-Error-Correcting Word Store with Write-Back Scrub

This block is a synchronous single-port word memory that keeps each 64-bit data word with eight check bits, as a 72-bit codeword. On a write the data is encoded with a Hamming code plus one overall parity bit. On a read the stored codeword is checked. A single flipped bit is repaired on the way out. Two flipped bits are reported and are not repaired.

A per-request switch turns error checking on or off. With checking off, the stored data bits come out unchanged and no event is reported. A second per-request switch lets a repaired read write the repaired codeword back to the same address. That costs one extra cycle, and `busy` holds off new requests during it. Two saturating counters keep track of repaired and unrepairable reads. A fault port XORs a mask into any stored codeword, so that error handling can be exercised at run time.

Top module: `ecc_scrub_mem`

## Requirements
- R1: While `rst_n` is low, and after it rises, `rsp_valid`, `busy`, both flags and both counters read zero. Every stored word is all-zero, which reads back clean as data 0.
- R2: A read is accepted on a rising edge where `req_valid` is high, `req_write` is low and `busy` is low. `rsp_valid` and `rsp_rdata` then hold for exactly the following cycle. A word read back with no faults equals the data written and raises no flag.
- R3: Codeword layout: bit 0 is the overall even-parity bit, and bits 1, 2, 4, 8, 16, 32 and 64 are Hamming check bits. The data bits fill the remaining positions in ascending order, so data bit 0 is at position 3 and data bit 63 is at position 71. When `ecc_en` is low, `rsp_rdata` is taken straight from those positions.
- R4: With `ecc_en` high, a single flipped bit at any of the 72 positions, including a check bit or the parity bit, is repaired in `rsp_rdata` and raises `rsp_corrected`.
- R5: With `ecc_en` high, two flipped bits raise `rsp_uncorrectable` and never `rsp_corrected`.
- R6: Odd overall parity together with a syndrome of 72 or more (for example, flips at positions 1, 8 and 64) is reported as uncorrectable.
- R7: A read accepted with `ecc_en` low raises no flag and leaves both counters unchanged.
- R8: A repaired read accepted with `scrub_en` high drives `busy` high during its response cycle. A request in that cycle is not accepted. The repaired codeword is written to the same address, so the next read of that address is clean.
- R9: With `scrub_en` low, a repaired read leaves the stored codeword unchanged, and the next read repairs it again.
- R10: `corr_count` rises by one on the edge that ends a response cycle with `rsp_corrected` high. `uncorr_count` does the same for `rsp_uncorrectable`.
- R11: Each counter stops at its all-ones value (2^CNT_W - 1).
- R12: `cnt_clr` zeroes both counters on the next edge, and this takes priority over an increment in the same cycle.
- R13: On the edge where `inj_valid` is high, `inj_mask` is XORed into the codeword at `inj_addr` with no re-encoding. Injecting the same mask twice restores the original codeword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | $clog2(DEPTH) | Word address |
| req_wdata | input | DATA_W | Write data |
| ecc_en | input | 1 | Check and repair on this read |
| scrub_en | input | 1 | Write back repaired codeword on this read |
| inj_valid | input | 1 | Apply fault mask this cycle |
| inj_addr | input | $clog2(DEPTH) | Address to corrupt |
| inj_mask | input | CW (72) | Bits to flip in the stored codeword |
| cnt_clr | input | 1 | Clear both counters |
| busy | output | 1 | Write-back in progress, request held off |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | DATA_W | Read data |
| rsp_corrected | output | 1 | Single error repaired on this read |
| rsp_uncorrectable | output | 1 | Error detected but not repaired |
| corr_count | output | CNT_W | Saturating count of repaired reads |
| uncorr_count | output | CNT_W | Saturating count of unrepairable reads |

## Verification
A read's data, flags and `busy` are due in the cycle right after the accepting edge. The bench drives inputs on falling edges and samples them at the next falling edge. Counter changes and write-backs land one edge after that. The bench therefore samples counters at the falling edge that follows the response cycle, and it observes a write-back only through a later read. During a `busy` cycle the bench offers a competing request and checks that no response comes one cycle later.

// File: rtl/ecc_pkg.sv
// Shared helpers for the SECDED word store: check-bit count, the mapping
// between codeword positions and data bits, and the read result type.
// Assumes position 0 holds overall parity and powers of two hold checks.
package ecc_pkg;

    typedef enum logic [1:0] {
        RES_CLEAN = 2'd0,
        RES_FIXED = 2'd1,
        RES_FATAL = 2'd2
    } dec_status_e;

    // Smallest Hamming check count p with 2^p >= data + p + 1
    function automatic int chk_bits(input int dw);
        int p;
        p = 1;
        while ((1 << p) < dw + p + 1) p++;
        return p;
    endfunction

    // True for the parity slot and every power-of-two slot
    function automatic bit is_check_pos(input int pos);
        return (pos == 0) || ((pos & (pos - 1)) == 0);
    endfunction

    // Data bit held at a non-check position
    function automatic int data_index(input int pos);
        return pos - $clog2(pos + 1) - 1;
    endfunction

endpackage

// File: rtl/ecc_encoder.sv
// Builds a SECDED codeword from a data word. Purely combinational.
// Assumes the ecc_pkg layout: parity at 0, checks at powers of two.
module ecc_encoder #(
    parameter int DATA_W = 64,
    localparam int P  = ecc_pkg::chk_bits(DATA_W),
    localparam int CW = DATA_W + P + 1
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [CW-1:0]     code_o
);

    logic [CW-1:0] body;
    logic          par;

    // Place data bits, leave check slots at zero
    for (genvar pos = 0; pos < CW; pos++) begin : g_pos
        if (ecc_pkg::is_check_pos(pos)) begin : g_chk
            assign body[pos] = 1'b0;
        end else begin : g_dat
            assign body[pos] = data_i[ecc_pkg::data_index(pos)];
        end
    end

    // Fill Hamming checks, then overall parity over the rest
    always_comb begin
        code_o = body;
        par    = 1'b0;
        for (int j = 0; j < P; j++) begin
            par = 1'b0;
            for (int pos = 1; pos < CW; pos++) begin
                if (((pos >> j) & 1) == 1) par = par ^ body[pos];
            end
            code_o[1 << j] = par;
        end
        code_o[0] = ^code_o[CW-1:1];
    end

endmodule

// File: rtl/ecc_decoder.sv
// Checks a SECDED codeword: syndrome, overall parity, repaired codeword
// and data. Purely combinational. A syndrome pointing past the last
// position with odd parity is treated as unrepairable.
module ecc_decoder #(
    parameter int DATA_W = 64,
    localparam int P  = ecc_pkg::chk_bits(DATA_W),
    localparam int CW = DATA_W + P + 1
) (
    input  logic [CW-1:0]        code_i,
    output logic [DATA_W-1:0]    raw_data_o,
    output logic [DATA_W-1:0]    fixed_data_o,
    output logic [CW-1:0]        fixed_code_o,
    output ecc_pkg::dec_status_e status_o
);

    logic [P-1:0] syn;
    logic         odd;

    // Syndrome: parity of each position group
    always_comb begin
        syn = '0;
        for (int j = 0; j < P; j++) begin
            for (int pos = 1; pos < CW; pos++) begin
                if (((pos >> j) & 1) == 1) syn[j] = syn[j] ^ code_i[pos];
            end
        end
    end

    assign odd = ^code_i;

    // Classify and repair the one bit the syndrome names
    always_comb begin
        fixed_code_o = code_i;
        if (!odd && syn == '0) begin
            status_o = ecc_pkg::RES_CLEAN;
        end else if (odd && int'(syn) < CW) begin
            status_o = ecc_pkg::RES_FIXED;
            fixed_code_o = code_i ^ ({{(CW-1){1'b0}}, 1'b1} << syn);
        end else begin
            status_o = ecc_pkg::RES_FATAL;
        end
    end

    // Pull data bits out of raw and repaired words
    for (genvar pos = 0; pos < CW; pos++) begin : g_ext
        if (!ecc_pkg::is_check_pos(pos)) begin : g_dat
            assign raw_data_o[ecc_pkg::data_index(pos)]   = code_i[pos];
            assign fixed_data_o[ecc_pkg::data_index(pos)] = fixed_code_o[pos];
        end
    end

endmodule

// File: rtl/ecc_sat_counter.sv
// Event counter that stops at all-ones and clears synchronously.
// Clear wins over a same-cycle increment.
module ecc_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);

    // Count up to the ceiling, clear on request
    always_ff @(posedge clk) begin
        if (!rst_n || clr)              count <= '0;
        else if (inc && count != '1)    count <= count + 1'b1;
    end

endmodule

// File: rtl/ecc_scrub_mem.sv
// Single-port SECDED word store with optional write-back of repaired
// reads, saturating event counters and a fault-injection port.
// Assumes one request per cycle; read data is registered one cycle.
module ecc_scrub_mem #(
    parameter int DATA_W = 64,
    parameter int DEPTH  = 16,
    parameter int CNT_W  = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = DATA_W + ecc_pkg::chk_bits(DATA_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [AW-1:0]     req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              ecc_en,
    input  logic              scrub_en,
    input  logic              inj_valid,
    input  logic [AW-1:0]     inj_addr,
    input  logic [CW-1:0]     inj_mask,
    input  logic              cnt_clr,
    output logic              busy,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_corrected,
    output logic              rsp_uncorrectable,
    output logic [CNT_W-1:0]  corr_count,
    output logic [CNT_W-1:0]  uncorr_count
);

    logic [CW-1:0]        mem_q   [DEPTH];
    logic [CW-1:0]        mem_nxt [DEPTH];
    logic [CW-1:0]        wr_code;
    logic [CW-1:0]        rd_code_q;
    logic [CW-1:0]        fix_code;
    logic [DATA_W-1:0]    raw_data;
    logic [DATA_W-1:0]    fix_data;
    logic [AW-1:0]        rd_addr_q;
    logic                 en_q;
    logic                 scrub_q;
    logic                 accept;
    ecc_pkg::dec_status_e status;

    assign accept = req_valid && !busy;

    ecc_encoder #(.DATA_W(DATA_W)) u_enc (
        .data_i (req_wdata),
        .code_o (wr_code)
    );

    ecc_decoder #(.DATA_W(DATA_W)) u_dec (
        .code_i       (rd_code_q),
        .raw_data_o   (raw_data),
        .fixed_data_o (fix_data),
        .fixed_code_o (fix_code),
        .status_o     (status)
    );

    // Capture the addressed codeword and read options
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rd_code_q <= '0;
            rd_addr_q <= '0;
            en_q      <= 1'b0;
            scrub_q   <= 1'b0;
        end else begin
            rsp_valid <= accept && !req_write;
            if (accept && !req_write) begin
                rd_code_q <= mem_q[req_addr];
                rd_addr_q <= req_addr;
                en_q      <= ecc_en;
                scrub_q   <= scrub_en;
            end
        end
    end

    // Response data and flags from the captured codeword
    assign rsp_rdata         = en_q ? fix_data : raw_data;
    assign rsp_corrected     = rsp_valid && en_q && status == ecc_pkg::RES_FIXED;
    assign rsp_uncorrectable = rsp_valid && en_q && status == ecc_pkg::RES_FATAL;
    assign busy              = rsp_corrected && scrub_q;

    // Next array contents: write-back or write, then fault mask on top
    always_comb begin
        for (int a = 0; a < DEPTH; a++) begin
            mem_nxt[a] = mem_q[a];
            if (busy && rd_addr_q == AW'(a))
                mem_nxt[a] = fix_code;
            if (accept && req_write && req_addr == AW'(a))
                mem_nxt[a] = wr_code;
            if (inj_valid && inj_addr == AW'(a))
                mem_nxt[a] = mem_nxt[a] ^ inj_mask;
        end
    end

    // Array storage, cleared to the all-zero valid codeword
    always_ff @(posedge clk) begin
        for (int a = 0; a < DEPTH; a++) begin
            if (!rst_n) mem_q[a] <= '0;
            else        mem_q[a] <= mem_nxt[a];
        end
    end

    ecc_sat_counter #(.W(CNT_W)) u_corr_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (rsp_corrected),
        .count (corr_count)
    );

    ecc_sat_counter #(.W(CNT_W)) u_uncorr_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (rsp_uncorrectable),
        .count (uncorr_count)
    );

endmodule

// File: rtl/ecc_scrub_mem_chk.sv
// Temporal checks on the word store's ports; bound into every instance.
module ecc_scrub_mem_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_write,
    input logic             ecc_en,
    input logic             cnt_clr,
    input logic             busy,
    input logic             rsp_valid,
    input logic             rsp_corrected,
    input logic             rsp_uncorrectable,
    input logic [CNT_W-1:0] corr_count,
    input logic [CNT_W-1:0] uncorr_count
);

    localparam logic [CNT_W-1:0] MAXV = '1;

    // R2
    rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !req_write && !busy));

    // R5
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_corrected && rsp_uncorrectable));

    // R7
    off_no_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_corrected || rsp_uncorrectable) |-> $past(ecc_en));

    // R8
    busy_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    // R8
    busy_on_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rsp_valid && rsp_corrected));

    // R10
    corr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_corrected && !cnt_clr && corr_count != MAXV)
        |=> corr_count == $past(corr_count) + 1'b1);

    // R10
    uncorr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rsp_uncorrectable && !cnt_clr) |=> $stable(uncorr_count));

    // R11
    corr_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (corr_count == MAXV && !cnt_clr) |=> corr_count == MAXV);

    // R12
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (corr_count == '0 && uncorr_count == '0));

endmodule

bind ecc_scrub_mem ecc_scrub_mem_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/ecc_scrub_mem_test.sv
// Self-checking bench: directed corner cases plus seeded random traffic,
// compared against a bench-side codeword model.
module ecc_scrub_mem_test;

    localparam int DW = 64;
    localparam int DEP = 16;
    localparam int CNTW = 4;
    localparam int CWB = 72;
    localparam int CMAX = 15;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0, req_write = 1'b0;
    logic [3:0]      req_addr = '0;
    logic [DW-1:0]   req_wdata = '0;
    logic            ecc_en = 1'b0, scrub_en = 1'b0;
    logic            inj_valid = 1'b0;
    logic [3:0]      inj_addr = '0;
    logic [CWB-1:0]  inj_mask = '0;
    logic            cnt_clr = 1'b0;
    logic            busy, rsp_valid, rsp_corrected, rsp_uncorrectable;
    logic [DW-1:0]   rsp_rdata;
    logic [CNTW-1:0] corr_count, uncorr_count;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    logic [CWB-1:0] model [DEP];
    int m_corr = 0;
    int m_unc  = 0;

    always #2 clk = ~clk;

    ecc_scrub_mem #(.DATA_W(DW), .DEPTH(DEP), .CNT_W(CNTW)) uut (.*);

    function automatic bit pow2(input int p);
        return (p & (p - 1)) == 0;
    endfunction

    function automatic logic [CWB-1:0] b_encode(input logic [DW-1:0] d);
        logic [CWB-1:0] c;
        int k;
        logic par;
        c = '0;
        k = 0;
        for (int p = 1; p < CWB; p++) if (!pow2(p)) begin c[p] = d[k]; k++; end
        for (int j = 0; j < 7; j++) begin
            par = 1'b0;
            for (int p = 1; p < CWB; p++) if (p[j]) par ^= c[p];
            c[1 << j] = par;
        end
        c[0] = ^c[CWB-1:1];
        return c;
    endfunction

    function automatic logic [DW-1:0] b_extract(input logic [CWB-1:0] c);
        logic [DW-1:0] d;
        int k;
        d = '0;
        k = 0;
        for (int p = 1; p < CWB; p++) if (!pow2(p)) begin d[k] = c[p]; k++; end
        return d;
    endfunction

    function automatic int b_syn(input logic [CWB-1:0] c);
        int s;
        s = 0;
        for (int p = 1; p < CWB; p++) if (c[p]) s ^= p;
        return s;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [CWB-1:0] act,
                       input logic [CWB-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input int a, input logic [DW-1:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 4'(a); req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        model[a] = b_encode(d);
    endtask

    task automatic do_inj(input int a, input logic [CWB-1:0] m);
        @(negedge clk);
        inj_valid = 1'b1; inj_addr = 4'(a); inj_mask = m;
        @(negedge clk);
        inj_valid = 1'b0;
        model[a] = model[a] ^ m;
    endtask

    // Read, check response cycle, then counters one edge later
    task automatic do_read(input int a, input bit en, input bit scr, input bit clr,
                           input string req);
        logic [CWB-1:0] cw;
        int s;
        bit odd, e_fix, e_bad, e_busy;
        logic [DW-1:0] e_data;
        cw  = model[a];
        s   = b_syn(cw);
        odd = ^cw;
        e_fix = en && odd && s < CWB;
        e_bad = en && !e_fix && (odd || s != 0);
        e_busy = e_fix && scr;
        e_data = e_fix ? b_extract(cw ^ (72'd1 << s)) : b_extract(cw);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 4'(a);
        ecc_en = en; scrub_en = scr;
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid == 1'b1, {req, " R2 valid"}, 72'(rsp_valid), 72'd1);
        if (!e_bad)
            chk(rsp_rdata == e_data, {req, " data"}, 72'(rsp_rdata), 72'(e_data));
        chk(rsp_corrected == e_fix && rsp_uncorrectable == e_bad, {req, " flags"},
            72'({rsp_corrected, rsp_uncorrectable}), 72'({e_fix, e_bad}));
        chk(busy == e_busy, {req, " R8 busy"}, 72'(busy), 72'(e_busy));
        cnt_clr = clr;
        if (e_busy) begin
            req_valid = 1'b1; req_addr = 4'(a ^ 1);
        end
        @(negedge clk);
        req_valid = 1'b0; cnt_clr = 1'b0;
        if (e_busy)
            chk(rsp_valid == 1'b0, "R8 stalled request accepted", 72'(rsp_valid), 72'd0);
        if (clr) begin
            m_corr = 0; m_unc = 0;
        end else begin
            if (e_fix && m_corr < CMAX) m_corr++;
            if (e_bad && m_unc < CMAX) m_unc++;
        end
        if (e_busy) model[a] = cw ^ (72'd1 << s);
        chk(corr_count == CNTW'(m_corr) && uncorr_count == CNTW'(m_unc),
            {req, " R10 counters"}, 72'({corr_count, uncorr_count}),
            72'({CNTW'(m_corr), CNTW'(m_unc)}));
    endtask

    task automatic do_clear();
        @(negedge clk);
        cnt_clr = 1'b1;
        @(negedge clk);
        cnt_clr = 1'b0;
        m_corr = 0; m_unc = 0;
        chk(corr_count == '0 && uncorr_count == '0, "R12 clear",
            72'({corr_count, uncorr_count}), 72'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d0;
        void'($urandom(32'd771));
        for (int a = 0; a < DEP; a++) model[a] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(rsp_valid == 0 && busy == 0 && corr_count == 0 && uncorr_count == 0,
            "R1 reset outputs", 72'({rsp_valid, busy, corr_count, uncorr_count}), 72'd0);
        rst_n = 1'b1;
        do_read(3, 1'b1, 1'b0, 1'b0, "R1 reset word");

        // R2 clean write and read
        d0 = 64'h0123_4567_89AB_CDEF;
        do_write(1, d0);
        do_read(1, 1'b1, 1'b0, 1'b0, "R2 clean");
        do_write(6, 64'hFFFF_FFFF_FFFF_FFFF);
        do_read(6, 1'b1, 1'b0, 1'b0, "R2 ones");

        // R3 layout via raw reads, R7 no flags or counts, R13 plain XOR
        do_write(2, d0);
        do_inj(2, 72'd1 << 3);
        do_read(2, 1'b0, 1'b0, 1'b0, "R3 pos3 data0 R7");
        chk(rsp_rdata == (d0 ^ 64'd1), "R3 data bit0 at pos3", 72'(rsp_rdata), 72'(d0 ^ 64'd1));
        do_inj(2, (72'd1 << 3) ^ (72'd1 << 71));
        do_read(2, 1'b0, 1'b1, 1'b0, "R3 pos71 R7");
        chk(rsp_rdata == (d0 ^ (64'd1 << 63)), "R3 data bit63 at pos71",
            72'(rsp_rdata), 72'(d0 ^ (64'd1 << 63)));
        do_inj(2, (72'd1 << 71) ^ (72'd1 << 64));
        do_read(2, 1'b0, 1'b0, 1'b0, "R3 check pos64 R7");
        chk(rsp_rdata == d0, "R3 check bit no data", 72'(rsp_rdata), 72'(d0));
        do_inj(2, 72'd1 << 64);
        do_read(2, 1'b1, 1'b0, 1'b0, "R13 double inject restores");

        // R4 every single-bit position, R11 saturation along the way
        do_clear();
        for (int p = 0; p < CWB; p++) begin
            do_write(5, {$urandom, $urandom});
            do_inj(5, 72'd1 << p);
            do_read(5, 1'b1, 1'b0, 1'b0, "R4 single");
        end
        chk(corr_count == CNTW'(CMAX), "R11 saturate", 72'(corr_count), 72'(CMAX));

        // R12 clear wins over increment in the same cycle
        do_read(5, 1'b1, 1'b0, 1'b1, "R12 clear beats inc");

        // R5 double errors
        do_write(7, d0);
        do_inj(7, (72'd1 << 10) | (72'd1 << 40));
        do_read(7, 1'b1, 1'b0, 1'b0, "R5 double");
        do_write(7, d0);
        do_inj(7, (72'd1 << 0) | (72'd1 << 5));
        do_read(7, 1'b1, 1'b1, 1'b0, "R5 parity plus data");

        // R6 syndrome past the end
        do_write(8, d0);
        do_inj(8, (72'd1 << 1) | (72'd1 << 8) | (72'd1 << 64));
        do_read(8, 1'b1, 1'b0, 1'b0, "R6 out of range");
        chk(rsp_corrected == 0, "R6 no repair", 72'(rsp_corrected), 72'd0);

        // R8 write-back then clean
        do_write(9, d0);
        do_inj(9, 72'd1 << 33);
        do_read(9, 1'b1, 1'b1, 1'b0, "R8 scrub");
        do_read(9, 1'b1, 1'b0, 1'b0, "R8 after scrub");

        // R9 no write-back: error stays
        do_inj(9, 72'd1 << 20);
        do_read(9, 1'b1, 1'b0, 1'b0, "R9 first");
        do_read(9, 1'b1, 1'b0, 1'b0, "R9 again");

        // Random traffic
        for (int i = 0; i < 200; i++) begin
            int a, nf, p1, p2;
            logic [CWB-1:0] m;
            a = int'($urandom % DEP);
            do_write(a, {$urandom, $urandom});
            nf = int'($urandom % 3);
            p1 = int'($urandom % CWB);
            p2 = (p1 + 1 + int'($urandom % (CWB - 1))) % CWB;
            m = '0;
            if (nf >= 1) m[p1] = 1'b1;
            if (nf == 2) m[p2] = 1'b1;
            if (nf != 0) do_inj(a, m);
            do_read(a, ($urandom % 4) != 0, $urandom % 2 == 1, ($urandom % 16) == 0,
                    "R4 R5 random");
            do_read(a, 1'b1, 1'b0, 1'b0, "R9 random reread");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule